// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block steers an external analog multiplexer across a contiguous band of input channels and requests one conversion from an attached converter for each accepted trigger. A host write port programs three things: the channel band (a low and a high bound), a per-channel range code (gain index, unipolar and differential flags), and a control word that enables the trigger sources. There are three trigger sources: a software strobe, a pacer tick and an external trigger pin.

For each conversion the sequencer presents the channel number and that channel's range code to the front end. It pulses a start request and holds both values unchanged until the converter answers with a done pulse carrying 12-bit data. It then emits a 16-bit word in which the top nibble names the source channel, so downstream software can detect lost samples. After each result it moves on to the next channel. When it passes the high bound it returns to the low bound. A band whose low bound is above its high bound wraps through channel 0.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `conv_start`, `smp_valid` and `overrun` are low. `mux_sel` is 0 and `range_code` is 0. All trigger sources are disabled.
- R2: A trigger is accepted only from an enabled source. Control word (address 3) bit 0 enables the software strobe, which is a write to address 0. Bit 1 enables `pacer_tick`. Bit 2 enables a rising edge of `ext_trig`. A trigger from a disabled source causes no start and does not move the channel.
- R3: An accepted trigger, sampled on a clock edge while idle, raises `conv_start` for exactly one cycle after that edge. From then until the done pulse is taken, `mux_sel` and `range_code` stay unchanged.
- R4: A `conv_done` taken while a conversion is open produces `smp_valid` for one cycle after that edge. `smp_data` carries the low 4 bits of the converted channel in bits 15:12 and `conv_data` in bits 11:0.
- R5: After each result the channel advances by one, modulo the channel count (16). After the channel equal to the high bound, the next channel is the low bound.
- R6: A write to address 2 sets the low bound from bits 7:0 and the high bound from bits 15:8. Within two cycles the channel returns to the low bound. Equal bounds keep the sequencer on one fixed channel.
- R7: A write to address 1 stores a range code for the channel currently on `mux_sel`. Bit 5 is differential, bit 4 is unipolar and bits 2:0 are the gain index. `range_code` shows the selected channel's code in the same bit positions, with bit 3 always zero.
- R8: On an odd channel the differential bit of a range write is dropped. The other fields are still stored.
- R9: An enabled trigger that arrives while a conversion is open is ignored: no extra start is issued and the channel does not move. It sets the sticky `overrun` flag, which only a control-word write or reset clears.
- R10: A `conv_done` pulse while no conversion is open produces no sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | 0 strobe, 1 range code, 2 channel band, 3 control |
| host_wdata | input | 16 | Host write data |
| pacer_tick | input | 1 | One-cycle pacer trigger |
| ext_trig | input | 1 | External trigger level, rising edge used |
| conv_start | output | 1 | One-cycle conversion request |
| conv_done | input | 1 | Converter finished, data valid |
| conv_data | input | 12 | Conversion result |
| mux_sel | output | 4 | Selected analog channel |
| range_code | output | 6 | Range code of selected channel |
| smp_valid | output | 1 | Tagged sample valid |
| smp_data | output | 16 | Channel tag and result |
| overrun | output | 1 | Sticky trigger-while-busy flag |

## Verification
A wrong channel pointer shows up at once: `mux_sel` at the next start differs from the expected channel, and the tag nibble on the following sample is wrong too. Within one band pass every bound and wrap decision is visible. A corrupted range table or a wrongly kept differential bit on an odd channel shows on `range_code` in the cycle after the write. A busy flag that is stuck or cleared too early shows as a missing or surplus start pulse, as a sample from a stray done pulse, or as an `overrun` value that differs from the model on the next trigger.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    A_STROBE   = 2'd0,
    A_RANGE    = 2'd1,
    A_INTERVAL = 2'd2,
    A_CONTROL  = 2'd3
  } host_addr_e;

  // stored code layout: {diff, uni, gain[2:0]}
  function automatic logic [4:0] clean_code(input logic [15:0] w, input logic odd_ch);
    return {w[5] & ~odd_ch, w[4], w[2:0]};
  endfunction

  function automatic logic [5:0] expand_code(input logic [4:0] c);
    return {c[4], c[3], 1'b0, c[2:0]};
  endfunction

  function automatic logic [7:0] next_chan(input logic [7:0] cur, input logic [7:0] lo,
                                           input logic [7:0] hi, input logic [8:0] nch);
    logic [8:0] inc;
    inc = {1'b0, cur} + 9'd1;
    if (cur == hi) return lo;
    if (inc >= nch) return 8'd0;
    return inc[7:0];
  endfunction

  function automatic logic [15:0] tag_word(input logic [7:0] ch, input logic [11:0] d);
    return {ch[3:0], d};
  endfunction

endpackage

// File: rtl/seq_regs.sv
module seq_regs
  import adc_seq_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_wr,
  input  logic [1:0]      host_addr,
  input  logic [15:0]     host_wdata,
  input  logic [CH_W-1:0] wr_ch,
  input  logic [CH_W-1:0] rd_ch,
  output logic [4:0]      rd_code,
  output logic [2:0]      ctrl_en,
  output logic            ctrl_wr,
  output logic            sw_strobe,
  output logic            reload,
  output logic [CH_W-1:0] band_lo,
  output logic [CH_W-1:0] band_hi
);

  logic [4:0] code_tab [NCH];

  assign sw_strobe = host_wr && (host_addr == A_STROBE);
  assign ctrl_wr   = host_wr && (host_addr == A_CONTROL);
  assign rd_code   = code_tab[rd_ch];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en <= '0;
      band_lo <= '0;
      band_hi <= '0;
      reload  <= 1'b0;
    end else begin
      reload <= 1'b0;
      if (ctrl_wr) ctrl_en <= host_wdata[2:0];
      if (host_wr && host_addr == A_INTERVAL) begin
        band_lo <= host_wdata[CH_W-1:0];
        band_hi <= host_wdata[8 +: CH_W];
        reload  <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_tab
    always_ff @(posedge clk) begin
      if (!rst_n) code_tab[g] <= '0;
      else if (host_wr && host_addr == A_RANGE && wr_ch == CH_W'(g))
        code_tab[g] <= clean_code(host_wdata, g[0]);
    end
  end

endmodule

// File: rtl/seq_trig.sv
module seq_trig (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ctrl_en,
  input  logic       sw_strobe,
  input  logic       pacer_tick,
  input  logic       ext_trig,
  output logic       trig
);

  logic ext_q;
  logic [2:0] src;

  always_ff @(posedge clk) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_trig;
  end

  // bit order follows the control word: 0 software, 1 pacer, 2 external edge
  assign src  = {ext_trig & ~ext_q, pacer_tick, sw_strobe};
  assign trig = |(src & ctrl_en);

endmodule

// File: rtl/seq_core.sv
module seq_core
  import adc_seq_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int CH_W = $clog2(NCH),
  parameter int DW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic            reload,
  input  logic            ovr_clr,
  input  logic [CH_W-1:0] band_lo,
  input  logic [CH_W-1:0] band_hi,
  input  logic [4:0]      ptr_code,
  input  logic            conv_done,
  input  logic [DW-1:0]   conv_data,
  output logic [CH_W-1:0] ptr,
  output logic [CH_W-1:0] act_ch,
  output logic [4:0]      act_code,
  output logic            busy,
  output logic            conv_start,
  output logic            smp_valid,
  output logic [15:0]     smp_data,
  output logic            overrun
);

  localparam logic [8:0] NCH9 = 9'(NCH);

  logic       take_trig;
  logic       take_done;
  logic [7:0] nxt;

  assign take_trig = trig && !busy;
  assign take_done = conv_done && busy;
  assign nxt = next_chan(8'(ptr), 8'(band_lo), 8'(band_hi), NCH9);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr        <= '0;
      act_ch     <= '0;
      act_code   <= '0;
      busy       <= 1'b0;
      conv_start <= 1'b0;
      smp_valid  <= 1'b0;
      smp_data   <= '0;
      overrun    <= 1'b0;
    end else begin
      conv_start <= take_trig;
      smp_valid  <= take_done;
      if (take_trig) begin
        busy     <= 1'b1;
        act_ch   <= ptr;
        act_code <= ptr_code;
      end
      if (take_done) begin
        busy     <= 1'b0;
        smp_data <= tag_word(8'(act_ch), conv_data);
      end
      if (reload)         ptr <= band_lo;
      else if (take_done) ptr <= nxt[CH_W-1:0];
      if (ovr_clr)              overrun <= 1'b0;
      else if (trig && busy)    overrun <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int CH_W = $clog2(NCH),
  parameter int DW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_wr,
  input  logic [1:0]      host_addr,
  input  logic [15:0]     host_wdata,
  input  logic            pacer_tick,
  input  logic            ext_trig,
  output logic            conv_start,
  input  logic            conv_done,
  input  logic [DW-1:0]   conv_data,
  output logic [CH_W-1:0] mux_sel,
  output logic [5:0]      range_code,
  output logic            smp_valid,
  output logic [15:0]     smp_data,
  output logic            overrun
);

  logic [2:0]      ctrl_en;
  logic            ctrl_wr;
  logic            sw_strobe;
  logic            reload;
  logic [CH_W-1:0] band_lo, band_hi;
  logic [4:0]      ptr_code, act_code;
  logic [CH_W-1:0] ptr, act_ch;
  logic            busy;
  logic            trig;

  assign mux_sel    = busy ? act_ch : ptr;
  assign range_code = expand_code(busy ? act_code : ptr_code);

  seq_regs #(.NCH(NCH), .CH_W(CH_W)) u_regs (
    .clk, .rst_n, .host_wr, .host_addr, .host_wdata,
    .wr_ch(mux_sel), .rd_ch(ptr), .rd_code(ptr_code),
    .ctrl_en, .ctrl_wr, .sw_strobe, .reload, .band_lo, .band_hi
  );

  seq_trig u_trig (
    .clk, .rst_n, .ctrl_en, .sw_strobe, .pacer_tick, .ext_trig, .trig
  );

  seq_core #(.NCH(NCH), .CH_W(CH_W), .DW(DW)) u_core (
    .clk, .rst_n, .trig, .reload, .ovr_clr(ctrl_wr), .band_lo, .band_hi,
    .ptr_code, .conv_done, .conv_data, .ptr, .act_ch, .act_code, .busy,
    .conv_start, .smp_valid, .smp_data, .overrun
  );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            trig,
  input logic            ctrl_wr,
  input logic            conv_start,
  input logic            conv_done,
  input logic            smp_valid,
  input logic [15:0]     smp_data,
  input logic [CH_W-1:0] mux_sel,
  input logic [5:0]      range_code,
  input logic            overrun
);

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_start_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);

  assert_hold_mux_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mux_sel) && $stable(range_code)));

  assert_sample_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> ($past(conv_done) && $past(busy)));

  assert_sample_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (smp_data[15:12] == 4'($past(mux_sel))));

  assert_odd_not_diff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    range_code[5] |-> !mux_sel[0]);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ctrl_wr) |=> overrun);

  assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && busy && !ctrl_wr) |=> overrun);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .trig(trig), .ctrl_wr(ctrl_wr),
  .conv_start(conv_start), .conv_done(conv_done), .smp_valid(smp_valid),
  .smp_data(smp_data), .mux_sel(mux_sel), .range_code(range_code),
  .overrun(overrun)
);

// File: tb/test_adc_scan_seq.sv
`timescale 1ns/1ps
module test_adc_scan_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        pacer_tick = 1'b0;
  logic        ext_trig = 1'b0;
  logic        conv_start;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic [3:0]  mux_sel;
  logic [5:0]  range_code;
  logic        smp_valid;
  logic [15:0] smp_data;
  logic        overrun;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int lo_m = 0, hi_m = 0, ptr_m = 0;
  logic [2:0] ctrl_m = '0;
  logic [4:0] tab_m [16];

  always #2.5 clk = ~clk;

  adc_scan_seq i_adc_scan_seq (
    .clk, .rst_n, .host_wr, .host_addr, .host_wdata, .pacer_tick, .ext_trig,
    .conv_start, .conv_done, .conv_data, .mux_sel, .range_code,
    .smp_valid, .smp_data, .overrun
  );

  function automatic int exp_next(int cur);
    if (cur == hi_m) return lo_m;
    return (cur + 1) % 16;
  endfunction

  function automatic logic [5:0] exp_range(int ch);
    logic [4:0] c;
    c = tab_m[ch];
    return {c[4], c[3], 1'b0, c[2:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic set_ctrl(input logic [2:0] c);
    wr(2'd3, {13'd0, c});
    ctrl_m = c;
  endtask

  task automatic set_band(input int l, input int h);
    wr(2'd2, {8'(h), 8'(l)});
    lo_m = l; hi_m = h; ptr_m = l;
    @(negedge clk);
    chk(mux_sel == 4'(l), "R6 band reload", mux_sel, l);
  endtask

  task automatic set_range(input logic [15:0] w);
    tab_m[ptr_m] = {w[5] & ~ptr_m[0], w[4], w[2:0]};
    wr(2'd1, w);
    chk(range_code == exp_range(ptr_m), ptr_m[0] ? "R8 odd range" : "R7 range",
        range_code, exp_range(ptr_m));
  endtask

  // src: 0 software, 1 pacer, 2 external
  task automatic convert(input int src, input int wait_n, input logic [11:0] d);
    bit fire;
    int ch;
    fire = ctrl_m[src];
    ch = ptr_m;
    case (src)
      0: begin host_wr = 1'b1; host_addr = 2'd0; end
      1: pacer_tick = 1'b1;
      default: ext_trig = 1'b1;
    endcase
    @(negedge clk);
    host_wr = 1'b0; pacer_tick = 1'b0; ext_trig = 1'b0;
    chk(conv_start == fire, "R2 source gating", conv_start, fire);
    chk(mux_sel == 4'(ch), "R3 channel at start", mux_sel, ch);
    if (!fire) return;
    chk(range_code == exp_range(ch), "R3 code at start", range_code, exp_range(ch));
    for (int i = 0; i < wait_n; i++) begin
      @(negedge clk);
      chk(conv_start == 1'b0 && mux_sel == 4'(ch), "R3 hold", mux_sel, ch);
    end
    conv_done = 1'b1; conv_data = d;
    @(negedge clk);
    conv_done = 1'b0;
    chk(smp_valid == 1'b1, "R4 valid", smp_valid, 1);
    chk(smp_data == {4'(ch), d}, "R4 word", smp_data, {4'(ch), d});
    ptr_m = exp_next(ch);
    @(negedge clk);
    chk(smp_valid == 1'b0, "R4 single valid", smp_valid, 0);
    chk(mux_sel == 4'(ptr_m), "R5 advance", mux_sel, ptr_m);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 16; i++) tab_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!conv_start && !smp_valid && !overrun, "R1 reset flags",
        {conv_start, smp_valid, overrun}, 0);
    chk(mux_sel == 0 && range_code == 0, "R1 reset select", {mux_sel, range_code}, 0);
    convert(0, 1, 12'h123);   // R2 disabled after reset

    // R2 each source alone
    set_ctrl(3'b001); convert(1, 0, 12'h001); convert(2, 0, 12'h002); convert(0, 2, 12'hABC);
    set_ctrl(3'b010); convert(0, 0, 12'h003); convert(1, 1, 12'h456);
    set_ctrl(3'b100); convert(1, 0, 12'h004); convert(2, 3, 12'h789);
    set_ctrl(3'b111);

    // R5 band 3..5 wraps to low bound
    set_band(3, 5);
    for (int i = 0; i < 4; i++) convert(i % 3, 1, 12'(i * 17));
    // R5 low above high wraps through channel 0
    set_band(14, 1);
    for (int i = 0; i < 5; i++) convert(0, 0, 12'hF00 + 12'(i));
    // R6 fixed channel
    set_band(9, 9);
    set_range(16'h0035);      // R8 odd channel: diff dropped
    for (int i = 0; i < 3; i++) convert(1, 1, 12'h0F0);
    set_band(8, 9);
    set_range(16'h003F);      // R7 even channel keeps diff, bit3 dropped
    convert(0, 0, 12'h555);
    chk(range_code == exp_range(9), "R8 odd channel code", range_code, exp_range(9));

    // R9 overrun
    wr(2'd0, 16'h0);
    chk(conv_start == 1'b1, "R9 first start", conv_start, 1);
    pacer_tick = 1'b1;
    @(negedge clk);
    pacer_tick = 1'b0;
    chk(conv_start == 1'b0, "R9 no extra start", conv_start, 0);
    chk(overrun == 1'b1, "R9 overrun set", overrun, 1);
    conv_done = 1'b1; conv_data = 12'h321;
    @(negedge clk);
    conv_done = 1'b0;
    chk(smp_data == {4'(ptr_m), 12'h321}, "R9 channel unchanged", smp_data, {4'(ptr_m), 12'h321});
    ptr_m = exp_next(ptr_m);
    @(negedge clk);
    chk(overrun == 1'b1, "R9 sticky", overrun, 1);
    set_ctrl(3'b111);
    chk(overrun == 1'b0, "R9 cleared by control write", overrun, 0);

    // R10 stray done
    conv_done = 1'b1; conv_data = 12'hEEE;
    @(negedge clk);
    conv_done = 1'b0;
    chk(smp_valid == 1'b0, "R10 idle done ignored", smp_valid, 1'b0);
    chk(mux_sel == 4'(ptr_m), "R10 channel unchanged", mux_sel, ptr_m);

    // random mix
    for (int n = 0; n < 300; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) set_band($urandom_range(0, 15), $urandom_range(0, 15));
      else if (r == 1) set_range(16'($urandom));
      else if (r == 2) set_ctrl(3'($urandom));
      else convert($urandom_range(0, 2), $urandom_range(0, 3), 12'($urandom));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule